// File: doc/BRIEF.md
# Two-Stage Card Clock Generator

This block derives one clock per card slot from a fast source clock. A first stage divides the source by a programmable integer and has a programmable high time. A bank of second-stage dividers then divides that clock by an even factor, or passes it straight through. Each slot chooses one of these dividers, and each slot has its own gating controls. All clock logic runs on the source clock, and every card clock output is a registered level.

Software writes staging registers through a simple write port. The values it writes do not reach the running clock logic until it issues an update-clock command and the block accepts it. The block accepts the command only at the end of a first-stage period in which every enabled slot's clock is low. At that moment the dividers restart cleanly, so no shortened pulse appears on a card clock. A busy flag shows while the command is in flight. Writing a second command while the first is still in flight raises a sticky lock error, and the second command is dropped.

Top module: `cclk_gen`

## Requirements
- R1: With a slot's divider at 0 (bypass), the slot's clock has a period of p+1 source cycles. p is register 0 bits [3:0], and a p of 0 acts as 1.
- R2: In bypass, the slot's clock is high for min(h,p-1)+1 source cycles of each period. h is register 0 bits [7:4].
- R3: With divider value M from 1 to 255, the slot's clock has a period of 2·M·(p+1) cycles and a high time of M·(p+1) cycles. Divider k is register 1 bits [8k+7:8k].
- R4: Slot s takes its clock from the divider whose index is in register 2 bits [2s+1:2s].
- R5: A slot whose enable bit is 0 keeps its clock output low. The enable for slot s is register 3 bit s.
- R6: A slot whose low-power bit is set drives low while ctrl_idle is high, and runs while ctrl_idle is low. The low-power bit for slot s is register 3 bit 16+s.
- R7: Writes to registers 0–3 do not change any output until an update command is accepted. An accepted update command applies the new values only when every enabled slot's clock is low.
- R8: A write to register 4 with bit 31 (start) and bit 21 (update) both set, made while the block is not busy, sets cmd_busy_o at the next edge. cmd_busy_o clears one cycle after the new values are committed.
- R9: A start write to register 4 while cmd_busy_o is high sets hle_o and is otherwise dropped. Writing 1 to register 5 bit 0 clears hle_o.
- R10: A start write without the update bit is ignored, and cmd_busy_o stays low.
- R11: Register 0 bit 8 inverts the output of every enabled slot.
- R12: After reset all card clocks are low, cmd_busy_o is 0 and hle_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| ctrl_idle | input | 1 | Controller idle indication, used for low-power gating |
| cclk_o | output | SLOTS | Card clock per slot |
| cmd_busy_o | output | 1 | Start bit of the update command, still pending |
| hle_o | output | 1 | Sticky lock error |

## Verification
The bench measures period and high time, edge to edge, on the slot outputs. It covers bypass with several values of p and h, including a high time that must be clamped. It covers the divided paths with M equal to 1, 2, 3 and 5, which separates the factor 2·M from the factor M and checks the 50% duty. It covers swaps of the source select, which show whether each slot decodes its own field. It repeats a measurement after a staged write that has no update command, which shows whether values leak through before commit. Back-to-back command writes, a start-only write and idle toggling with low-power set separate the lock error, the ignored command and the gating paths from normal running.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  localparam int ADDR_W        = 3;
  localparam int CMD_START_BIT = 31;
  localparam int CMD_UPD_BIT   = 21;
  localparam int GATE_LP_LSB   = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_STAGE1 = 3'd0,
    A_DIVS   = 3'd1,
    A_SRCSEL = 3'd2,
    A_GATE   = 3'd3,
    A_CMD    = 3'd4,
    A_STATUS = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/cclk_regs.sv
module cclk_regs
  import cclk_pkg::*;
#(
  parameter int PW    = 4,
  parameter int DIVW  = 8,
  parameter int NDIV  = 4,
  parameter int SLOTS = 2,
  parameter int SELW  = 2,
  parameter int DW    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   safe,
  output logic [PW-1:0]          p_live,
  output logic [PW-1:0]          h_live,
  output logic                   inv_live,
  output logic [NDIV*DIVW-1:0]   m_live,
  output logic [SLOTS*SELW-1:0]  src_live,
  output logic [SLOTS-1:0]       en_live,
  output logic [SLOTS-1:0]       lp_live,
  output logic                   busy,
  output logic                   hle,
  output logic                   commit
);
  localparam int INV_BIT = 2 * PW;

  logic [PW-1:0]         p_stg, h_stg;
  logic                  inv_stg;
  logic [NDIV*DIVW-1:0]  m_stg;
  logic [SLOTS*SELW-1:0] src_stg;
  logic [SLOTS-1:0]      en_stg, lp_stg;
  logic                  pend, done;

  assign commit = pend & safe;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_stg <= PW'(1); h_stg <= '0; inv_stg <= 1'b0;
      m_stg <= '0; src_stg <= '0; en_stg <= '0; lp_stg <= '0;
      p_live <= PW'(1); h_live <= '0; inv_live <= 1'b0;
      m_live <= '0; src_live <= '0; en_live <= '0; lp_live <= '0;
      busy <= 1'b0; pend <= 1'b0; done <= 1'b0; hle <= 1'b0;
    end else begin
      done <= commit;
      if (done) busy <= 1'b0;
      if (commit) begin
        pend     <= 1'b0;
        p_live   <= p_stg;
        h_live   <= h_stg;
        inv_live <= inv_stg;
        m_live   <= m_stg;
        src_live <= src_stg;
        en_live  <= en_stg;
        lp_live  <= lp_stg;
      end
      if (wr_en) begin
        case (wr_addr)
          A_STAGE1: begin
            p_stg   <= wr_data[PW-1:0];
            h_stg   <= wr_data[PW +: PW];
            inv_stg <= wr_data[INV_BIT];
          end
          A_DIVS:   m_stg   <= wr_data[NDIV*DIVW-1:0];
          A_SRCSEL: src_stg <= wr_data[SLOTS*SELW-1:0];
          A_GATE: begin
            en_stg <= wr_data[SLOTS-1:0];
            lp_stg <= wr_data[GATE_LP_LSB +: SLOTS];
          end
          A_CMD: begin
            if (wr_data[CMD_START_BIT]) begin
              if (busy) hle <= 1'b1;
              else if (wr_data[CMD_UPD_BIT]) begin
                busy <= 1'b1;
                pend <= 1'b1;
              end
            end
          end
          A_STATUS: if (wr_data[0]) hle <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cclk_stage1.sv
module cclk_stage1 #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] p,
  input  logic [PW-1:0] h,
  output logic          lvl,
  output logic          wrap
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] p_eff;

  assign p_eff = (p == '0) ? PW'(1) : p;
  assign wrap  = (cnt >= p_eff);
  assign lvl   = (cnt <= h) && !wrap;

  always_ff @(posedge clk) begin
    if (rst || wrap) cnt <= '0;
    else             cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/cclk_div2.sv
module cclk_div2 #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            adv,
  input  logic [DIVW-1:0] m,
  input  logic            s1,
  output logic            lvl_o
);
  logic [DIVW-1:0] mcnt;
  logic            dlvl;

  assign lvl_o = (m == '0) ? s1 : dlvl;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mcnt <= '0;
      dlvl <= 1'b0;
    end else if (adv && m != '0) begin
      if (mcnt >= m - DIVW'(1)) begin
        mcnt <= '0;
        dlvl <= ~dlvl;
      end else begin
        mcnt <= mcnt + DIVW'(1);
      end
    end
  end
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
  import cclk_pkg::*;
#(
  parameter int PW    = 4,
  parameter int DIVW  = 8,
  parameter int NDIV  = 4,
  parameter int SLOTS = 2,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              ctrl_idle,
  output logic [SLOTS-1:0]  cclk_o,
  output logic              cmd_busy_o,
  output logic              hle_o
);
  localparam int SELW = (NDIV > 1) ? $clog2(NDIV) : 1;

  logic [PW-1:0]         p_live, h_live;
  logic                  inv_live;
  logic [NDIV*DIVW-1:0]  m_live;
  logic [SLOTS*SELW-1:0] src_live;
  logic [SLOTS-1:0]      en_live, lp_live;
  logic                  commit, safe, s1_lvl, wrap;
  logic [NDIV-1:0]       div_lvl;
  logic [SLOTS-1:0]      slot_lvl, gate_on, raw_q, cclk_q;

  cclk_regs #(.PW(PW), .DIVW(DIVW), .NDIV(NDIV), .SLOTS(SLOTS),
              .SELW(SELW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .safe(safe), .p_live(p_live), .h_live(h_live),
    .inv_live(inv_live), .m_live(m_live), .src_live(src_live),
    .en_live(en_live), .lp_live(lp_live), .busy(cmd_busy_o),
    .hle(hle_o), .commit(commit)
  );

  cclk_stage1 #(.PW(PW)) u_stage1 (
    .clk(clk), .rst(rst), .p(p_live), .h(h_live), .lvl(s1_lvl), .wrap(wrap)
  );

  for (genvar k = 0; k < NDIV; k++) begin : g_div
    cclk_div2 #(.DIVW(DIVW)) u_div (
      .clk(clk), .rst(rst), .clr(commit), .adv(wrap),
      .m(m_live[k*DIVW +: DIVW]), .s1(s1_lvl), .lvl_o(div_lvl[k])
    );
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      slot_lvl[s] = div_lvl[src_live[s*SELW +: SELW]];
      gate_on[s]  = en_live[s] & ~(lp_live[s] & ctrl_idle);
    end
  end

  // commit only at end of a stage-1 period with every enabled slot low
  assign safe = wrap & ~|(en_live & slot_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      cclk_q <= '0;
    end else begin
      raw_q  <= gate_on & slot_lvl;
      cclk_q <= gate_on & (slot_lvl ^ {SLOTS{inv_live}});
    end
  end

  assign cclk_o = cclk_q;
endmodule

// File: rtl/cclk_gen_chk.sv
module cclk_gen_chk
  import cclk_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int DW    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              cmd_busy_o,
  input logic              hle_o,
  input logic              commit,
  input logic [SLOTS-1:0]  raw_q,
  input logic [SLOTS-1:0]  cclk_o,
  input logic [SLOTS-1:0]  en_live
);
  logic cmd_start;
  assign cmd_start = wr_en && (wr_addr == A_CMD) && wr_data[CMD_START_BIT];

  // R9
  hle_on_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_busy_o) |=> hle_o);

  // R8
  busy_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> cmd_busy_o);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_busy_o) |-> $past(commit, 2));

  // R10
  no_upd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !wr_data[CMD_UPD_BIT] && !cmd_busy_o) |=> !cmd_busy_o);

  // R7
  low_at_commit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_busy_o) |-> ($past(raw_q) == '0));

  // R5
  gated_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cclk_o & ~$past(en_live)) == '0);
endmodule

bind cclk_gen cclk_gen_chk #(.SLOTS(SLOTS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cmd_busy_o(cmd_busy_o), .hle_o(hle_o), .commit(commit),
  .raw_q(raw_q), .cclk_o(cclk_o), .en_live(en_live)
);

// File: tb/tb_cclk_gen.sv
module tb_cclk_gen;
  localparam int SLOTS = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic             ctrl_idle = 1'b0;
  logic [SLOTS-1:0] cclk_o;
  logic             cmd_busy_o, hle_o;

  int nvec = 0;
  int nbad = 0;
  bit finished = 1'b0;

  cclk_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_idle(ctrl_idle), .cclk_o(cclk_o), .cmd_busy_o(cmd_busy_o), .hle_o(hle_o)
  );

  always #5 clk = ~clk;

  localparam logic [31:0] CMD_UPD = 32'h8020_0000;

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic update();
    wr(3'd4, CMD_UPD);
    for (int i = 0; i < 20000; i++) begin
      if (!cmd_busy_o) break;
      @(negedge clk);
    end
    chk("R8 busy cleared", int'(cmd_busy_o), 0);
  endtask

  task automatic measure(input int s, output int per, output int hi);
    logic prev;
    per = 0; hi = 0;
    @(negedge clk);
    prev = cclk_o[s];
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!prev && cclk_o[s]) break;
      prev = cclk_o[s];
    end
    per = 1; hi = 1; prev = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!prev && cclk_o[s]) break;
      per++;
      if (cclk_o[s]) hi++;
      prev = cclk_o[s];
    end
  endtask

  task automatic expect_clk(input string req, input int s, input int ep, input int eh);
    int per, hi;
    measure(s, per, hi);
    chk({req, " period"}, per, ep);
    chk({req, " high"}, hi, eh);
  endtask

  task automatic stay_low(input string req, input int s, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cclk_o[s]) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic t_reset();
    chk("R12 clocks low", int'(cclk_o), 0);
    chk("R12 busy", int'(cmd_busy_o), 0);
    chk("R12 hle", int'(hle_o), 0);
  endtask

  task automatic t_bypass();
    wr(3'd0, 32'h13);            // p=3 h=1
    wr(3'd3, 32'h1);             // slot0 enabled
    update();
    expect_clk("R1 R2 p3h1", 0, 4, 2);
    wr(3'd0, 32'h26);            // staged p=6 h=2, no update
    expect_clk("R7 staged not applied", 0, 4, 2);
    update();
    expect_clk("R1 p6h2", 0, 7, 3);
    wr(3'd0, 32'h94);            // p=4 h=9 clamps
    update();
    expect_clk("R2 clamp", 0, 5, 4);
    wr(3'd0, 32'h06);
    update();
    expect_clk("R2 p6h0", 0, 7, 1);
  endtask

  task automatic t_divided();
    wr(3'd0, 32'h01);            // p=1 h=0
    wr(3'd1, (32'd5 << 24) | (32'd2 << 16) | (32'd3 << 8));
    wr(3'd2, 32'd1 << 2);        // slot1 -> divider 1
    wr(3'd3, 32'h3);
    update();
    expect_clk("R3 M3", 1, 12, 6);
    expect_clk("R1 bypass p1", 0, 2, 1);
    wr(3'd1, (32'd5 << 24) | (32'd2 << 16) | (32'd1 << 8));
    update();
    expect_clk("R3 M1", 1, 4, 2);
  endtask

  task automatic t_srcsel();
    wr(3'd2, (32'd3 << 2) | 32'd2);
    update();
    expect_clk("R4 slot0 div2", 0, 8, 4);
    expect_clk("R4 slot1 div3", 1, 20, 10);
  endtask

  task automatic t_enable();
    wr(3'd3, 32'h1);
    update();
    stay_low("R5 slot1 disabled", 1, 100);
    expect_clk("R5 slot0 running", 0, 8, 4);
  endtask

  task automatic t_lowpower();
    wr(3'd3, 32'h0001_0001);
    update();
    ctrl_idle = 1'b1;
    @(negedge clk); @(negedge clk);
    stay_low("R6 idle gated", 0, 100);
    ctrl_idle = 1'b0;
    expect_clk("R6 resumed", 0, 8, 4);
  endtask

  task automatic t_invert();
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h103);           // p=3 h=0 invert
    update();
    expect_clk("R11 inverted", 0, 4, 3);
  endtask

  task automatic t_handshake();
    int rose = 0;
    wr(3'd4, CMD_UPD);
    chk("R8 busy set", int'(cmd_busy_o), 1);
    wr(3'd4, CMD_UPD);
    chk("R9 hle set", int'(hle_o), 1);
    for (int i = 0; i < 20000; i++) begin
      if (!cmd_busy_o) break;
      @(negedge clk);
    end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cmd_busy_o) rose++;
    end
    chk("R9 second command dropped", rose, 0);
    chk("R9 hle sticky", int'(hle_o), 1);
    wr(3'd5, 32'h1);
    chk("R9 hle cleared", int'(hle_o), 0);
  endtask

  task automatic t_no_update();
    int seen = 0;
    wr(3'd4, 32'h8000_0000);
    for (int i = 0; i < 5; i++) begin
      if (cmd_busy_o) seen++;
      @(negedge clk);
    end
    chk("R10 start without update", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_divided();
    t_srcsel();
    t_enable();
    t_lowpower();
    t_invert();
    t_handshake();
    t_no_update();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      nvec++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule